// File: doc/BRIEF.md
# Ring Buffer Playback Reader

This block streams audio samples out of a circular buffer held in memory. Software programs a start pointer and an end pointer, pulses an init bit, and sets the fetch and drain enables. From then on the fetch side reads the buffer in 8-byte bursts and wraps back to the start on its own. The drain side unpacks each burst into 16-bit or 32-bit samples for the serializer that follows. The end pointer names the first byte of the final burst, not the byte past the buffer.

Fetched bursts sit in a small staging FIFO. A new burst is requested only when the staging FIFO has room for it. The drain side counts the bytes it hands out. Each time that count reaches the programmed period length, it raises a one-cycle interrupt so software can refill the part of the ring that has already been played. Software can read the fetch pointer back at any time to find the playback position.

Top module: `ringdma_top`

## Requirements
- R1: After reset every register reads zero, `mem_req`, `out_valid` and `period_irq` are low.
- R2: Register slots on `reg_addr` are: 0 start pointer, 1 end pointer, 2 fetch pointer, 3 control, 4 staging clear, 5 period length (16 bits), 6 output control. The three pointer registers always read with bits [2:0] zero, and the period register keeps only bits [15:0].
- R3: A burst request is issued at the fetch pointer only under all of these conditions: control bit 1 (fetch enable) is set, output-control bit 0 (output enable) is set, control bit 0 is clear, no burst is outstanding, and the staging FIFO has room for 8 bytes. When the request is granted, the fetch pointer advances by 8.
- R4: When the burst at the end-pointer address is granted, the fetch pointer returns to the start pointer, so playback repeats the bytes from start through end+7.
- R5: Samples leave when control bit 2 (drain enable) and output bit 0 are set. With control bit 7 clear, each sample is 4 consecutive bytes in little-endian order. With bit 7 set, each sample is 2 bytes in little-endian order, zero-extended to 32 bits.
- R6: With drain enabled and the staging FIFO empty, `out_valid` stays low and the pointers do not move.
- R7: While control bit 0 is set: the fetch pointer is held at the start pointer, the staging FIFO is emptied, the period byte count is cleared, no request is issued, and a burst still in flight is discarded when it returns.
- R8: Staging-clear bit 0 empties the staging FIFO and leaves the pointers untouched.
- R9: The period count adds the bytes of each sample handed out. When it equals a non-zero period length, it restarts at zero, and if output-control bit 3 is set, `period_irq` is high for exactly the following cycle.
- R10: Writes to the start, end or fetch pointer are ignored while control bit 1 or bit 2 is set.
- R11: With the output stalled, at most DEPTH bursts are staged and the fetch pointer stops DEPTH*8 bytes past where it began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register slot |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Burst address, 8-byte aligned |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Burst data returned |
| mem_rdata | input | 64 | Burst data, lowest address in bits [7:0] |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Serializer takes the sample |
| out_data | output | 32 | Sample |
| period_irq | output | 1 | One-cycle period interrupt |

## Verification
The init flush and a burst returning from memory can land in the same cycle, or the init can come while that burst is still pending. The bench provokes this with a slow memory model. It points the fetch pointer into the middle of the ring, lets one burst be granted, and writes the init bit before the data comes back. It then judges that the first sample after restart comes from the start pointer and not from the stale burst. The period count is also checked to have restarted from zero.

// File: rtl/ringdma_pkg.sv
package ringdma_pkg;

    localparam int ADDR_W     = 32;
    localparam int BEAT_BYTES = 8;
    localparam int BEAT_W     = BEAT_BYTES * 8;
    localparam int SEL_W      = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_START   = 3'd0,
        SEL_END     = 3'd1,
        SEL_RDPTR   = 3'd2,
        SEL_CTRL    = 3'd3,
        SEL_STGCLR  = 3'd4,
        SEL_PERIOD  = 3'd5,
        SEL_OUTCTL  = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic half_mode;   // control bit 7
        logic drain_en;    // control bit 2
        logic fetch_en;    // control bit 1
        logic init;        // control bit 0
    } ctrl_t;

    typedef struct packed {
        logic irq_on_period;  // output-control bit 3
        logic out_en;         // output-control bit 0
    } outctl_t;

    function automatic logic [ADDR_W-1:0] align_beat(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:3], 3'b000};
    endfunction

endpackage

// File: rtl/ringdma_fetch.sv
module ringdma_fetch
    import ringdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              room,
    input  logic              flush,
    input  logic              sw_wr,
    input  logic [ADDR_W-1:0] sw_ptr,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic [ADDR_W-1:0] end_ptr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] rdptr,
    output logic              pend,
    output logic              keep
);
    logic drop;

    assign mem_req  = go && room && !pend && !flush;
    assign mem_addr = rdptr;
    assign keep     = mem_rvalid && !drop && !flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdptr <= '0;
            pend  <= 1'b0;
            drop  <= 1'b0;
        end else begin
            if (flush)
                rdptr <= start_ptr;
            else if (sw_wr)
                rdptr <= sw_ptr;
            else if (mem_req && mem_gnt)
                rdptr <= (rdptr == end_ptr) ? start_ptr : rdptr + ADDR_W'(BEAT_BYTES);

            if (mem_req && mem_gnt)
                pend <= 1'b1;
            else if (mem_rvalid)
                pend <= 1'b0;

            if (mem_rvalid)
                drop <= 1'b0;
            else if (flush && pend)
                drop <= 1'b1;
        end
    end

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt && rdptr == end_ptr && !sw_wr) |=> rdptr == $past(start_ptr));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt && rdptr != end_ptr && !sw_wr) |=> rdptr == $past(rdptr) + ADDR_W'(BEAT_BYTES));

endmodule

// File: rtl/ringdma_stage.sv
module ringdma_stage
    import ringdma_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [BEAT_W-1:0] push_data,
    input  logic              pend,
    input  logic              half,
    input  logic              drain_go,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [31:0]       out_data,
    output logic              room,
    output logic              pop,
    output logic [2:0]        pop_bytes
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = IDX_W + 1;

    logic [BEAT_W-1:0] store [DEPTH];
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [CNT_W-1:0]  count;
    logic [2:0]        off;
    logic [BEAT_W-1:0] head;
    logic [31:0]       word;
    logic              last;

    assign head      = store[rd_idx];
    assign out_valid = drain_go && (count != '0);
    assign pop       = out_valid && out_ready;
    assign pop_bytes = half ? 3'd2 : 3'd4;
    assign last      = ({1'b0, off} + {1'b0, pop_bytes}) >= 4'd8;
    assign room      = (count + CNT_W'(pend)) < CNT_W'(DEPTH);
    assign out_data  = half ? {16'h0000, word[15:0]} : word;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            logic [2:0] bi;
            bi = off + 3'(i);
            word[8*i +: 8] = head[8*bi +: 8];
        end
    end

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] x);
        return (x == IDX_W'(DEPTH - 1)) ? '0 : x + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !flush && !rst)
            store[wr_idx] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
            off    <= '0;
        end else begin
            if (push)
                wr_idx <= next_idx(wr_idx);
            if (pop) begin
                off <= last ? 3'd0 : off + pop_bytes;
                if (last)
                    rd_idx <= next_idx(rd_idx);
            end
            count <= count + CNT_W'(push) - CNT_W'(pop && last);
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0) && !out_valid);

    assert_empty_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !push) |=> !out_valid);

endmodule

// File: rtl/ringdma_period.sv
module ringdma_period #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             pop,
    input  logic [2:0]       step,
    input  logic [CNT_W-1:0] target,
    input  logic             irq_en,
    output logic             irq
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   sum;
    logic             hit;

    assign sum = {1'b0, cnt} + (CNT_W+1)'(step);
    assign hit = pop && (target != '0) && (sum == {1'b0, target});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= hit && irq_en;
            if (pop)
                cnt <= hit ? '0 : sum[CNT_W-1:0];
        end
    end

    assert_irq_after_pop_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(pop));

endmodule

// File: rtl/ringdma_top.sv
module ringdma_top
    import ringdma_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int PERIOD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [BEAT_W-1:0] mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic              period_irq
);
    logic [ADDR_W-1:0]   start_q, end_q, rdptr;
    ctrl_t               ctrl_q;
    outctl_t             outctl_q;
    logic                stgclr_q;
    logic [PERIOD_W-1:0] period_q;
    logic                running, ptr_ok;
    logic                room, pend, keep, pop;
    logic [2:0]          pop_bytes;

    assign running = ctrl_q.fetch_en || ctrl_q.drain_en;
    assign ptr_ok  = reg_wr && !running;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q  <= '0;
            end_q    <= '0;
            ctrl_q   <= '0;
            outctl_q <= '0;
            stgclr_q <= 1'b0;
            period_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                SEL_START:  if (ptr_ok) start_q <= align_beat(reg_wdata);
                SEL_END:    if (ptr_ok) end_q   <= align_beat(reg_wdata);
                SEL_CTRL:   ctrl_q   <= '{half_mode: reg_wdata[7], drain_en: reg_wdata[2],
                                          fetch_en: reg_wdata[1], init: reg_wdata[0]};
                SEL_STGCLR: stgclr_q <= reg_wdata[0];
                SEL_PERIOD: period_q <= reg_wdata[PERIOD_W-1:0];
                SEL_OUTCTL: outctl_q <= '{irq_on_period: reg_wdata[3], out_en: reg_wdata[0]};
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            SEL_START:  reg_rdata = start_q;
            SEL_END:    reg_rdata = end_q;
            SEL_RDPTR:  reg_rdata = rdptr;
            SEL_CTRL:   reg_rdata = {24'h0, ctrl_q.half_mode, 4'h0, ctrl_q.drain_en,
                                     ctrl_q.fetch_en, ctrl_q.init};
            SEL_STGCLR: reg_rdata = {31'h0, stgclr_q};
            SEL_PERIOD: reg_rdata = 32'(period_q);
            SEL_OUTCTL: reg_rdata = {28'h0, outctl_q.irq_on_period, 2'b00, outctl_q.out_en};
            default:    reg_rdata = '0;
        endcase
    end

    ringdma_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .go         (ctrl_q.fetch_en && outctl_q.out_en),
        .room       (room),
        .flush      (ctrl_q.init),
        .sw_wr      (ptr_ok && reg_addr == SEL_RDPTR),
        .sw_ptr     (align_beat(reg_wdata)),
        .start_ptr  (start_q),
        .end_ptr    (end_q),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .rdptr      (rdptr),
        .pend       (pend),
        .keep       (keep)
    );

    ringdma_stage #(.DEPTH(DEPTH)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .flush      (ctrl_q.init || stgclr_q),
        .push       (keep),
        .push_data  (mem_rdata),
        .pend       (pend),
        .half       (ctrl_q.half_mode),
        .drain_go   (ctrl_q.drain_en && outctl_q.out_en),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .room       (room),
        .pop        (pop),
        .pop_bytes  (pop_bytes)
    );

    ringdma_period #(.CNT_W(PERIOD_W)) u_period (
        .clk    (clk),
        .rst    (rst),
        .clear  (ctrl_q.init),
        .pop    (pop),
        .step   (pop_bytes),
        .target (period_q),
        .irq_en (outctl_q.irq_on_period),
        .irq    (period_irq)
    );

    assert_ptr_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && running && (reg_addr == SEL_START || reg_addr == SEL_END))
            |=> (start_q == $past(start_q)) && (end_q == $past(end_q)));

    assert_init_no_req_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.init |-> !mem_req);

endmodule

// File: tb/ringdma_top_bench.sv
`timescale 1ns/1ps
module ringdma_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b1;
    logic        mem_rvalid;
    logic [63:0] mem_rdata;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        period_irq;

    int total = 0;
    int bad = 0;
    int lat = 1;

    always #2.5 clk = ~clk;

    ringdma_top u_ringdma_top (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .period_irq(period_irq)
    );

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return a[7:0] ^ a[15:8];
    endfunction

    function automatic logic [63:0] burst(input logic [31:0] a);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = mbyte(a + 32'(i));
        return r;
    endfunction

    function automatic logic [31:0] sample(input logic [31:0] p, input logic half);
        if (half) return {16'h0, mbyte(p + 1), mbyte(p)};
        return {mbyte(p + 3), mbyte(p + 2), mbyte(p + 1), mbyte(p)};
    endfunction

    // memory responder: one burst in flight, fixed latency
    int          lat_cnt = 0;
    logic [31:0] pend_addr = '0;
    always @(posedge clk) begin
        if (rst) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            lat_cnt    <= 0;
        end else begin
            mem_rvalid <= 1'b0;
            if (lat_cnt > 0) begin
                lat_cnt <= lat_cnt - 1;
                if (lat_cnt == 1) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= burst(pend_addr);
                end
            end else if (mem_req && mem_gnt) begin
                pend_addr <= mem_addr;
                lat_cnt   <= lat;
            end
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5 d = reg_rdata;
    endtask

    task automatic pop(output logic [31:0] d, output logic ir, output logic ok);
        int w = 0;
        @(negedge clk);
        while (!out_valid && w < 2000) begin @(negedge clk); w++; end
        ok = out_valid;
        d  = out_data;
        ir = 1'b0;
        if (ok) begin
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            ir = period_irq;
        end
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] e, input logic [31:0] per,
                         input logic [31:0] oc, input logic half);
        wr(3, 0);
        wr(0, s);
        wr(1, e);
        wr(5, per);
        wr(6, oc);
        wr(3, 1);
        wr(3, 0);
        wr(3, {24'h0, half, 7'b0000110});
    endtask

    // play n samples, checking data (R5, R4 wrap) and interrupt placement (R9)
    task automatic play(input int n, input logic [31:0] s, input logic [31:0] e,
                        input logic [31:0] per, input logic half, inout logic [31:0] p,
                        inout int bytes, input string tag);
        logic [31:0] d;
        logic ir, ok, exp_ir;
        for (int k = 0; k < n; k++) begin
            pop(d, ir, ok);
            check(ok, {tag, " sample present"}, 32'(ok), 1);
            check(d == sample(p, half), {tag, " data"}, d, sample(p, half));
            bytes += half ? 2 : 4;
            p     += half ? 2 : 4;
            if (p == e + 8) p = s;
            exp_ir = (bytes % per) == 0;
            check(ir == exp_ir, {tag, " R9 irq"}, 32'(ir), 32'(exp_ir));
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            check(d == 0, "R1 register reset", d, 0);
        end
        check(!mem_req && !out_valid && !period_irq, "R1 outputs idle",
              {29'h0, mem_req, out_valid, period_irq}, 0);
    endtask

    task automatic t_align;
        logic [31:0] d;
        wr(0, 32'h0000_1007); rd(0, d);
        check(d == 32'h1000, "R2 start low bits", d, 32'h1000);
        wr(1, 32'h0000_10FF); rd(1, d);
        check(d == 32'h10F8, "R2 end low bits", d, 32'h10F8);
        wr(2, 32'h0000_2223); rd(2, d);
        check(d == 32'h2220, "R2 rdptr low bits", d, 32'h2220);
        wr(5, 32'h0001_2345); rd(5, d);
        check(d == 32'h2345, "R2 period width", d, 32'h2345);
    endtask

    task automatic t_play32;
        logic [31:0] p = 32'h2000;
        int b = 0;
        setup(32'h2000, 32'h2018, 16, 9, 1'b0);
        play(20, 32'h2000, 32'h2018, 16, 1'b0, p, b, "R5 R4 32-bit");
    endtask

    task automatic t_play16;
        logic [31:0] p = 32'h3100;
        int b = 0;
        setup(32'h3100, 32'h3108, 24, 9, 1'b1);
        play(30, 32'h3100, 32'h3108, 24, 1'b1, p, b, "R5 R4 16-bit");
    endtask

    task automatic t_init;
        logic [31:0] p = 32'h4000;
        logic [31:0] d;
        int b = 0;
        setup(32'h4000, 32'h40F8, 16, 9, 1'b0);
        play(2, 32'h4000, 32'h40F8, 16, 1'b0, p, b, "R7 pre");
        wr(3, 0);
        wr(3, 1);
        rd(2, d);
        check(d == 32'h4000, "R7 init rewinds rdptr", d, 32'h4000);
        wr(3, 0);
        wr(3, 6);
        p = 32'h4000; b = 0;
        play(4, 32'h4000, 32'h40F8, 16, 1'b0, p, b, "R7 after init");
    endtask

    task automatic t_ignore_underflow;
        logic [31:0] r, s, d, dd;
        logic ir, ok;
        int n = 0;
        wr(3, 4);
        rd(2, r);
        wr(2, 32'h7000);
        wr(0, 32'h7000);
        rd(2, d);
        check(d == r, "R10 rdptr write ignored", d, r);
        rd(0, s);
        check(s == 32'h4000, "R10 start write ignored", s, 32'h4000);
        while (out_valid && n < 64) begin pop(dd, ir, ok); n++; end
        repeat (10) @(negedge clk);
        check(!out_valid, "R6 underflow holds valid low", 32'(out_valid), 0);
        rd(2, d);
        check(d == r, "R6 rdptr unchanged on underflow", d, r);
    endtask

    task automatic t_backpressure;
        logic [31:0] d;
        setup(32'h5000, 32'h5FF8, 0, 9, 1'b0);
        repeat (50) @(negedge clk);
        rd(2, d);
        check(d == 32'h5020, "R11 fetch stops at depth", d, 32'h5020);
        check(out_valid, "R11 staged data offered", 32'(out_valid), 1);
        wr(3, 4);
        wr(4, 1);
        wr(4, 0);
        repeat (5) @(negedge clk);
        check(!out_valid, "R8 staging clear empties", 32'(out_valid), 0);
        rd(2, d);
        check(d == 32'h5020, "R8 rdptr untouched", d, 32'h5020);
    endtask

    task automatic t_out_off;
        logic [31:0] d;
        int reqs = 0;
        setup(32'h5800, 32'h58F8, 16, 8, 1'b0);
        repeat (20) begin @(negedge clk); if (mem_req) reqs++; end
        check(reqs == 0 && !out_valid, "R3 no fetch without output enable", 32'(reqs), 0);
        rd(2, d);
        check(d == 32'h5800, "R3 rdptr held", d, 32'h5800);
    endtask

    task automatic t_flush_inflight;
        logic [31:0] p = 32'h6000;
        int b = 0;
        int w = 0;
        lat = 6;
        wr(3, 0);
        wr(0, 32'h6000);
        wr(1, 32'h60F8);
        wr(5, 16);
        wr(6, 9);
        wr(2, 32'h6040);
        wr(3, 2);
        @(negedge clk);
        while (!mem_req && w < 100) begin @(negedge clk); w++; end
        wr(3, 1);
        wr(3, 0);
        wr(3, 6);
        play(6, 32'h6000, 32'h60F8, 16, 1'b0, p, b, "R7 in-flight discard");
        lat = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_align;
        t_play32;
        t_play16;
        t_init;
        t_ignore_underflow;
        t_backpressure;
        t_out_off;
        t_flush_inflight;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule